// File: doc/BRIEF.md
# Command/Indication Code Receiver

This block sits behind the serial deframer of a time-division multiplexed subscriber bus. It watches the bus's two Command/Indication fields. Once per frame, on a one-cycle frame strobe, it takes in a 4-bit primary code and a 6-bit secondary code, along with two channel-status indications: Stop/Go and bus ownership. The results go into a register that the host reads.

The primary code is accepted only when it has the same value in two frames in a row. Accepted codes go into a receive field. If the host has not yet read the code held there, the newest accepted code waits in a single pending slot. A slow host therefore always sees the first unread code and the latest one, and any codes in between are dropped. The secondary code has no filter: it is reported as soon as it changes. Each code has a change flag, and one host read strobe clears both flags.

Top module: `ci_code_rx`

## Requirements
- R1: A primary code counts as validated only if it has the same value on two consecutive frame strobes. A code seen on one strobe only never reaches `ci0_code` and never sets `ci0_chg`.
- R2: A validated code is written into `ci0_code` only while `ci0_chg` is 0, meaning the host has read the code already there. Otherwise the validated code is held as pending.
- R3: While `ci0_chg` is 1, every further validated code replaces the pending one, and `ci0_code` does not change. The first read after that moves the pending code (the latest one) into `ci0_code`. Codes that were overwritten in the pending slot are lost.
- R4: `ci0_chg` goes to 1 in the cycle after a validated code is written into `ci0_code`. A read with no pending code clears it. A read that moves a pending code into `ci0_code` leaves it at 1.
- R5: On any frame strobe where the 6-bit secondary input differs from `ci1_code`, both `ci1_code` and `ci1_chg` are updated on that same strobe. A read clears `ci1_chg`, unless a new change arrives in the same cycle, in which case the change wins.
- R6: `sg_stat` takes the value of `stop_in` on each frame strobe. A value of 1 means stop and 0 means go.
- R7: `bas_stat` takes the value of `own_in` on each frame strobe. A value of 1 means this device holds the D and C/I channels, and 0 means another device holds them.
- R8: After reset, `ci0_code` is 4'b1111 and `ci1_code` is 6'b111111. The pending slot is empty and all four flag and status outputs are 0. The two-frame filter starts with 4'b1111 as its last sample.
- R9: A validated code that equals the most recently validated code is ignored: neither `ci0_code` nor `ci0_chg` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally |
| frame_stb | input | 1 | One-cycle pulse per frame; the fields below are valid with it |
| ci0_in | input | 4 | Primary C/I code sampled this frame |
| ci1_in | input | 6 | Secondary C/I code sampled this frame |
| stop_in | input | 1 | Upstream D-channel stop indication |
| own_in | input | 1 | This device currently owns the D and C/I channels |
| rd_stb | input | 1 | One-cycle host read of the status register |
| ci0_code | output | 4 | Primary receive field |
| ci1_code | output | 6 | Secondary code field |
| ci0_chg | output | 1 | Primary code change flag |
| ci1_chg | output | 1 | Secondary code change flag |
| sg_stat | output | 1 | Stop/Go status (1 = stop) |
| bas_stat | output | 1 | Bus-access status (1 = owned here) |

## Verification
If the filter's last-sample or last-validated register is wrong, the block either accepts a one-frame glitch or misses a genuine change. This appears at `ci0_code` and `ci0_chg` one cycle after the second frame strobe. A corrupt pending slot stays hidden until the next host read, and then shows up as a wrong second code or a `ci0_chg` that fails to set again. The bench therefore compares every output against an independent model in every cycle. Long random runs with few reads make the pending path reach those reads often.

// File: rtl/ci_rx_pkg.sv
package ci_rx_pkg;
  localparam int unsigned CI0_W_DEF = 4;
  localparam int unsigned CI1_W_DEF = 6;
endpackage

// File: rtl/ci0_persist.sv
module ci0_persist #(
  parameter int unsigned W = ci_rx_pkg::CI0_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic [W-1:0] code_in,
  output logic         new_vld,
  output logic [W-1:0] new_code
);
  localparam logic [W-1:0] IDLE = {W{1'b1}};

  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] last_q, last_d;
  logic         hit;

  always_comb begin
    hit    = frame_stb && (code_in == prev_q) && (code_in != last_q);
    prev_d = prev_q;
    last_d = last_q;
    if (frame_stb) prev_d = code_in;
    if (hit)       last_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
      last_q <= IDLE;
    end else begin
      prev_q <= prev_d;
      last_q <= last_d;
    end
  end

  assign new_vld  = hit;
  assign new_code = code_in;

  // R1: validation happens only on a frame strobe
  p_vld_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    new_vld |-> frame_stb);
  // R9: a repeat of the last validated code is not reported again
  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_vld |=> !(new_vld && new_code == $past(new_code)));
endmodule

// File: rtl/ci0_holdoff.sv
module ci0_holdoff #(
  parameter int unsigned W = ci_rx_pkg::CI0_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         new_vld,
  input  logic [W-1:0] new_code,
  input  logic         rd_stb,
  output logic [W-1:0] rx_code,
  output logic         rx_chg
);
  logic [W-1:0] rx_q, rx_d, pend_q, pend_d;
  logic         pv_q, pv_d, chg_q, chg_d;

  always_comb begin
    rx_d   = rx_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    chg_d  = chg_q;
    if (rd_stb) begin
      chg_d = 1'b0;
      if (pv_q) begin
        rx_d  = pend_q;
        pv_d  = 1'b0;
        chg_d = 1'b1;
      end
    end
    if (new_vld) begin
      if (!chg_d) begin
        rx_d  = new_code;
        chg_d = 1'b1;
      end else begin
        pend_d = new_code;
        pv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= {W{1'b1}};
      pend_q <= {W{1'b1}};
      pv_q   <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      rx_q   <= rx_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      chg_q  <= chg_d;
    end
  end

  assign rx_code = rx_q;
  assign rx_chg  = chg_q;

  // R2 / R3: an unread code is never overwritten
  p_hold_unread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q && !rd_stb) |=> $stable(rx_q));
  // R3: a read with a pending code delivers it and flags it
  p_pend_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && pv_q) |=> (chg_q && rx_q == $past(pend_q)));
  // R4: a plain read clears the flag
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pv_q && !new_vld) |=> !chg_q);
  // R4: a validated code always leaves the flag set
  p_set_on_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_vld |=> chg_q);
endmodule

// File: rtl/ci1_change.sv
module ci1_change #(
  parameter int unsigned W = ci_rx_pkg::CI1_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic [W-1:0] code_in,
  input  logic         rd_stb,
  output logic [W-1:0] code_out,
  output logic         chg
);
  logic [W-1:0] code_q, code_d;
  logic         chg_q, chg_d;

  always_comb begin
    code_d = code_q;
    chg_d  = chg_q;
    if (rd_stb) chg_d = 1'b0;
    if (frame_stb && (code_in != code_q)) begin
      code_d = code_in;
      chg_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= {W{1'b1}};
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      chg_q  <= chg_d;
    end
  end

  assign code_out = code_q;
  assign chg      = chg_q;

  // R5: single-frame change detection
  p_set_one_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && code_in != code_q) |=> (chg_q && code_q == $past(code_in)));
  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !frame_stb) |=> !chg_q);
endmodule

// File: rtl/ci_code_rx.sv
module ci_code_rx #(
  parameter int unsigned CI0_W = ci_rx_pkg::CI0_W_DEF,
  parameter int unsigned CI1_W = ci_rx_pkg::CI1_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [CI0_W-1:0] ci0_in,
  input  logic [CI1_W-1:0] ci1_in,
  input  logic             stop_in,
  input  logic             own_in,
  input  logic             rd_stb,
  output logic [CI0_W-1:0] ci0_code,
  output logic [CI1_W-1:0] ci1_code,
  output logic             ci0_chg,
  output logic             ci1_chg,
  output logic             sg_stat,
  output logic             bas_stat
);
  logic [1:0] rst_sync_q;
  logic       rst_li;
  logic       nv;
  logic [CI0_W-1:0] nc;
  logic       sg_q, sg_d, bas_q, bas_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_li = rst_sync_q[1];

  ci0_persist #(.W(CI0_W)) u_persist (
    .clk(clk), .rst_n(rst_li), .frame_stb(frame_stb), .code_in(ci0_in),
    .new_vld(nv), .new_code(nc));

  ci0_holdoff #(.W(CI0_W)) u_holdoff (
    .clk(clk), .rst_n(rst_li), .new_vld(nv), .new_code(nc), .rd_stb(rd_stb),
    .rx_code(ci0_code), .rx_chg(ci0_chg));

  ci1_change #(.W(CI1_W)) u_ci1 (
    .clk(clk), .rst_n(rst_li), .frame_stb(frame_stb), .code_in(ci1_in),
    .rd_stb(rd_stb), .code_out(ci1_code), .chg(ci1_chg));

  always_comb begin
    sg_d  = sg_q;
    bas_d = bas_q;
    if (frame_stb) begin
      sg_d  = stop_in;
      bas_d = own_in;
    end
  end

  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li) begin
      sg_q  <= 1'b0;
      bas_q <= 1'b0;
    end else begin
      sg_q  <= sg_d;
      bas_q <= bas_d;
    end
  end

  assign sg_stat  = sg_q;
  assign bas_stat = bas_q;

  p_sg_capture_r6: assert property (@(posedge clk) disable iff (!rst_li)
    frame_stb |=> (sg_stat == $past(stop_in)));
  p_bas_capture_r7: assert property (@(posedge clk) disable iff (!rst_li)
    frame_stb |=> (bas_stat == $past(own_in)));
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_li)
    !frame_stb |=> ($stable(sg_stat) && $stable(bas_stat)));
endmodule

// File: tb/sim_ci_code_rx.sv
module sim_ci_code_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_stb, stop_in, own_in, rd_stb;
  logic [3:0] ci0_in;
  logic [5:0] ci1_in;
  logic [3:0] ci0_code;
  logic [5:0] ci1_code;
  logic       ci0_chg, ci1_chg, sg_stat, bas_stat;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [3:0] m_prev, m_last, m_rx, m_pend;
  logic       m_pv, m_c0, m_c1, m_sg, m_bas;
  logic [5:0] m_c1code;

  always #2.5 clk = ~clk;

  ci_code_rx u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ci0_in(ci0_in),
    .ci1_in(ci1_in), .stop_in(stop_in), .own_in(own_in), .rd_stb(rd_stb),
    .ci0_code(ci0_code), .ci1_code(ci1_code), .ci0_chg(ci0_chg),
    .ci1_chg(ci1_chg), .sg_stat(sg_stat), .bas_stat(bas_stat));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic nv_of(logic fs, logic [3:0] c);
    return fs && (c == m_prev) && (c != m_last);
  endfunction

  task automatic model_reset();
    m_prev = 4'hF; m_last = 4'hF; m_rx = 4'hF; m_pend = 4'hF;
    m_pv = 0; m_c0 = 0; m_c1 = 0; m_sg = 0; m_bas = 0; m_c1code = 6'h3F;
  endtask

  task automatic model_step();
    logic nv;
    nv = nv_of(frame_stb, ci0_in);
    if (frame_stb) begin
      m_prev = ci0_in;
      if (nv) m_last = ci0_in;
    end
    if (rd_stb) begin
      m_c0 = 0;
      if (m_pv) begin m_rx = m_pend; m_pv = 0; m_c0 = 1; end
    end
    if (nv) begin
      if (!m_c0) begin m_rx = ci0_in; m_c0 = 1; end
      else begin m_pend = ci0_in; m_pv = 1; end
    end
    if (rd_stb) m_c1 = 0;
    if (frame_stb && ci1_in != m_c1code) begin m_c1code = ci1_in; m_c1 = 1; end
    if (frame_stb) begin m_sg = stop_in; m_bas = own_in; end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " ci0_code"}, {4'h0, ci0_code}, {4'h0, m_rx});
    chk({req, " ci0_chg"}, {7'h0, ci0_chg}, {7'h0, m_c0});
    chk({req, " ci1_code"}, {2'h0, ci1_code}, {2'h0, m_c1code});
    chk({req, " ci1_chg"}, {7'h0, ci1_chg}, {7'h0, m_c1});
    chk({req, " sg_stat"}, {7'h0, sg_stat}, {7'h0, m_sg});
    chk({req, " bas_stat"}, {7'h0, bas_stat}, {7'h0, m_bas});
  endtask

  // drive at negedge, model follows the posedge, compare at next negedge
  task automatic cycle(logic fs, logic [3:0] c0, logic [5:0] c1,
                       logic st, logic ow, logic rd, string req);
    frame_stb = fs; ci0_in = c0; ci1_in = c1; stop_in = st; own_in = ow; rd_stb = rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    frame_stb = 0; rd_stb = 0;
    chk_all(req);
  endtask

  task automatic frame(logic [3:0] c0, logic [5:0] c1, string req);
    cycle(1'b1, c0, c1, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic rd(string req);
    cycle(1'b0, ci0_in, ci1_in, stop_in, own_in, 1'b1, req);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 0; frame_stb = 0; rd_stb = 0; stop_in = 0; own_in = 0;
    ci0_in = 4'hF; ci1_in = 6'h3F;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_all("R8 reset");

    // R1: one-frame glitch ignored, then two-frame code accepted
    frame(4'h3, 6'h3F, "R1 glitch");
    frame(4'h5, 6'h3F, "R1 glitch2");
    chk("R1 no accept", {4'h0, ci0_code}, 8'h0F);
    frame(4'h5, 6'h3F, "R1 accept");
    chk("R1 accepted", {4'h0, ci0_code}, 8'h05);
    chk("R4 flag set", {7'h0, ci0_chg}, 8'h01);
    // R9: repeat of validated code ignored after read
    rd("R4 read clear");
    chk("R4 cleared", {7'h0, ci0_chg}, 8'h00);
    frame(4'h5, 6'h3F, "R9 repeat");
    chk("R9 no flag", {7'h0, ci0_chg}, 8'h00);
    // R2/R3: three codes without read: first kept, last pending, middle lost
    frame(4'h1, 6'h3F, "R3"); frame(4'h1, 6'h3F, "R2 first");
    frame(4'h2, 6'h3F, "R3"); frame(4'h2, 6'h3F, "R3 mid");
    frame(4'h7, 6'h3F, "R3"); frame(4'h7, 6'h3F, "R3 last");
    chk("R2 first held", {4'h0, ci0_code}, 8'h01);
    rd("R3 first read");
    chk("R3 latest moved", {4'h0, ci0_code}, 8'h07);
    chk("R4 flag reasserted", {7'h0, ci0_chg}, 8'h01);
    rd("R3 second read");
    chk("R4 cleared after second", {7'h0, ci0_chg}, 8'h00);
    // R5: single-frame secondary change, read clears
    frame(4'h7, 6'h2A, "R5 change");
    chk("R5 flag", {7'h0, ci1_chg}, 8'h01);
    rd("R5 read");
    // R6/R7 status capture, and no change without strobe
    cycle(1'b1, 4'h7, 6'h2A, 1'b1, 1'b1, 1'b0, "R6 R7 set");
    cycle(1'b0, 4'h7, 6'h2A, 1'b0, 1'b0, 1'b0, "R6 R7 hold");
    cycle(1'b1, 4'h7, 6'h2A, 1'b0, 1'b1, 1'b0, "R6 R7 go");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c0;
      c0 = 4'($urandom_range(0, 3)) | 4'h4;
      cycle(($urandom_range(0, 2) == 0), c0, 6'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 9) == 0), "R1-9 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule